// File: doc/BRIEF.md
# Dual-Lane Reed-Solomon (7,3) Frame Encoder with Pair Serializer

This block protects a 16-bit word with two independent Reed-Solomon (7,3) codes over GF(8) and sends the protected result as a stream of 2-bit pairs. Each byte of the input word is extended with one zero bit to nine bits and read as three 3-bit message symbols. A systematic shift-register encoder computes four parity symbols for each byte. Each of the seven codeword symbols is widened to a 4-bit nibble, and each seven-nibble codeword is padded to 32 bits. The two 32-bit halves are joined into a 64-bit frame.

The frame is emitted two bits per transfer over a valid/ready stream. The upper bit of each pair feeds the in-phase branch of a downstream modulator and the lower bit feeds the quadrature branch. A new word is taken over a valid/ready input handshake only when the previous frame has been sent completely. A word accepted in one cycle becomes the first pair on the output in the next cycle.

Top module: `rs73_pair_encoder`

## Requirements
- R1: Field arithmetic uses GF(8) generated by x^3 + x + 1, with α = 3'b010. Every codeword the block emits evaluates to zero at α^1, α^2, α^3 and α^4.
- R2: The code is systematic. Codeword symbols c6, c5 and c4 are the message symbols {1'b0, byte[7:6]}, byte[5:3] and byte[2:0], in that order.
- R3: Parity symbols c3..c0 are the remainder of X^4·m(X) divided by g(X) = X^4 + α^3·X^3 + X^2 + α·X + α^3, where m(X) = c6·X^2 + c5·X + c4.
- R4: A 32-bit half holds symbol ci in bits [4i+2:4i]. Bit 4i+3 is zero for every i, and bits [31:28] are zero.
- R5: The codeword of in_word[15:8] forms frame bits [63:32], and the codeword of in_word[7:0] forms frame bits [31:0].
- R6: Frame bits go out most significant pair first. In pair p (p = 0..31), out_pair[1] (in-phase) is frame bit 63−2p and out_pair[0] (quadrature) is frame bit 62−2p.
- R7: Each frame produces exactly 32 out_valid/out_ready transfers. While out_valid is high and out_ready is low, out_valid stays high and out_pair is unchanged.
- R8: in_ready is low from the cycle after a word is accepted until the cycle after the 32nd pair is transferred. in_valid and in_word have no effect while in_ready is low.
- R9: After reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word (no frame pending) |
| in_word | input | 16 | Two data bytes; upper byte forms the upper frame half |
| out_valid | output | 1 | out_pair holds a frame pair |
| out_ready | input | 1 | Downstream takes the pair this cycle |
| out_pair | output | 2 | Bit 1 in-phase, bit 0 quadrature |

## Verification
A wrong generator coefficient or a wrong feedback tap in the shift-register encoder corrupts the parity nibbles of the affected half. This shows up in the first frame with a non-zero byte, because the received symbols then fail the zero test at α^1..α^4. A wrong pair counter or shift step lengthens or shortens the frame, or reorders its bits. That appears at the end of the first frame, where the bench sees the wrong number of transfers or a misplaced in_ready. A stall bug shows as a changed pair during backpressure in the very cycle after the stall.

// File: rtl/rs73_pkg.sv
package rs73_pkg;

    localparam int SYM_W = 3;
    localparam logic [SYM_W:0] PRIM_POLY = 4'b1011;
    localparam int FIELD_ORDER = (1 << SYM_W) - 1;
    localparam int MAX_PAR = 7;

    typedef logic [SYM_W-1:0] sym_t;
    typedef sym_t [MAX_PAR:0] gpoly_t;

    // Shift-and-add multiply; with one constant operand it reduces to XORs
    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t x;
        acc = '0;
        x   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ x;
            if (x[SYM_W-1]) x = {x[SYM_W-2:0], 1'b0} ^ PRIM_POLY[SYM_W-1:0];
            else            x = {x[SYM_W-2:0], 1'b0};
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(int e);
        sym_t r;
        r = sym_t'(1);
        for (int i = 0; i < e; i++) r = gf_mul(r, sym_t'(2));
        return r;
    endfunction

    // Product of (X + alpha^r) for r = 1..par, coefficient j at index j
    function automatic gpoly_t gen_poly(int par);
        gpoly_t g;
        sym_t   root;
        g    = '0;
        g[0] = sym_t'(1);
        for (int r = 1; r <= par; r++) begin
            root = gf_alpha_pow(r);
            for (int j = MAX_PAR; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(root, g[j]);
            g[0] = gf_mul(root, g[0]);
        end
        return g;
    endfunction

endpackage

// File: rtl/rs73_msg_map.sv
module rs73_msg_map
    import rs73_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int K_SYM  = 3
) (
    input  logic [DATA_W-1:0]      data_in,
    output logic [K_SYM*SYM_W-1:0] msg_out
);
    localparam int MSG_W = K_SYM * SYM_W;
    localparam int PAD_B = MSG_W - DATA_W;

    // Zero filler on top: the highest message symbol carries it
    generate
        if (PAD_B > 0) begin : g_pad
            assign msg_out = {{PAD_B{1'b0}}, data_in};
        end else begin : g_nopad
            assign msg_out = data_in[MSG_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/rs73_lfsr_enc.sv
module rs73_lfsr_enc
    import rs73_pkg::*;
#(
    parameter int K_SYM   = 3,
    parameter int PAR_SYM = 4
) (
    input  logic [K_SYM*SYM_W-1:0]   msg_in,
    output logic [PAR_SYM*SYM_W-1:0] parity_out
);
    localparam gpoly_t GEN = gen_poly(PAR_SYM);

    // rem[s] is the division register after s message symbols
    sym_t rem [0:K_SYM][0:PAR_SYM-1];

    generate
        for (genvar j = 0; j < PAR_SYM; j++) begin : g_init
            assign rem[0][j] = '0;
        end
        for (genvar s = 0; s < K_SYM; s++) begin : g_step
            sym_t msym_d;
            sym_t fb_d;
            assign msym_d = msg_in[(K_SYM-1-s)*SYM_W +: SYM_W];
            assign fb_d   = msym_d ^ rem[s][PAR_SYM-1];
            assign rem[s+1][0] = gf_mul(GEN[0], fb_d);
            for (genvar j = 1; j < PAR_SYM; j++) begin : g_tap
                assign rem[s+1][j] = rem[s][j-1] ^ gf_mul(GEN[j], fb_d);
            end
        end
        for (genvar j = 0; j < PAR_SYM; j++) begin : g_out
            assign parity_out[j*SYM_W +: SYM_W] = rem[K_SYM][j];
        end
    endgenerate
endmodule

// File: rtl/rs73_nibble_pack.sv
module rs73_nibble_pack
    import rs73_pkg::*;
#(
    parameter int N_SYM  = 7,
    parameter int HALF_W = 32
) (
    input  logic [N_SYM*SYM_W-1:0] cw_in,
    output logic [HALF_W-1:0]      half_out
);
    localparam int NIB_W = SYM_W + 1;
    localparam int PAD_W = HALF_W - N_SYM * NIB_W;

    generate
        for (genvar i = 0; i < N_SYM; i++) begin : g_nib
            assign half_out[i*NIB_W +: NIB_W] =
                {{(NIB_W-SYM_W){1'b0}}, cw_in[i*SYM_W +: SYM_W]};
        end
        if (PAD_W > 0) begin : g_pad
            assign half_out[HALF_W-1 -: PAD_W] = '0;
        end
    endgenerate
endmodule

// File: rtl/rs73_pair_serializer.sv
module rs73_pair_serializer #(
    parameter int FRAME_W = 64,
    parameter int PAIR_W  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_valid,
    output logic               load_ready,
    input  logic [FRAME_W-1:0] load_frame,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [PAIR_W-1:0]  out_pair
);
    localparam int NUM_PAIRS = FRAME_W / PAIR_W;
    localparam int CNT_W     = $clog2(NUM_PAIRS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_PAIRS - 1);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] shreg;
    } ser_state_t;

    ser_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (load_valid) begin
                st_d.busy  = 1'b1;
                st_d.cnt   = '0;
                st_d.shreg = load_frame;
            end
        end else if (out_ready) begin
            st_d.shreg = st_q.shreg << PAIR_W;
            st_d.cnt   = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST_IDX) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load_ready = !st_q.busy;
    assign out_valid  = st_q.busy;
    assign out_pair   = st_q.shreg[FRAME_W-1 -: PAIR_W];

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pair)); // R7
    AST_LOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid && load_ready |=> out_valid && !load_ready); // R8
    AST_FRAME_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && (st_q.cnt == LAST_IDX) |=> !out_valid && load_ready); // R7
    AST_FRAME_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && (st_q.cnt != LAST_IDX) |=> out_valid); // R7
endmodule

// File: rtl/rs73_pair_encoder.sv
module rs73_pair_encoder
    import rs73_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LANES  = 2,
    parameter int N_SYM  = 7,
    parameter int K_SYM  = 3,
    parameter int HALF_W = 32,
    parameter int PAIR_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*DATA_W-1:0] in_word,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [PAIR_W-1:0]       out_pair
);
    localparam int PAR_SYM = N_SYM - K_SYM;
    localparam int MSG_W   = K_SYM * SYM_W;
    localparam int PAR_W   = PAR_SYM * SYM_W;
    localparam int CW_W    = N_SYM * SYM_W;
    localparam int FRAME_W = LANES * HALF_W;

    logic [FRAME_W-1:0] frame_d;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            logic [MSG_W-1:0] msg_d;
            logic [PAR_W-1:0] par_d;
            logic [CW_W-1:0]  cw_d;
            logic             roots_clear;

            rs73_msg_map #(.DATA_W(DATA_W), .K_SYM(K_SYM)) u_map (
                .data_in (in_word[l*DATA_W +: DATA_W]),
                .msg_out (msg_d)
            );
            rs73_lfsr_enc #(.K_SYM(K_SYM), .PAR_SYM(PAR_SYM)) u_enc (
                .msg_in     (msg_d),
                .parity_out (par_d)
            );
            assign cw_d = {msg_d, par_d};
            rs73_nibble_pack #(.N_SYM(N_SYM), .HALF_W(HALF_W)) u_pack (
                .cw_in    (cw_d),
                .half_out (frame_d[l*HALF_W +: HALF_W])
            );

            // Evaluation at the generator roots, independent of the division path
            always_comb begin
                sym_t acc;
                roots_clear = 1'b1;
                for (int j = 1; j <= PAR_SYM; j++) begin
                    acc = '0;
                    for (int i = 0; i < N_SYM; i++) begin
                        acc = acc ^ gf_mul(cw_d[i*SYM_W +: SYM_W],
                                           gf_alpha_pow((i * j) % FIELD_ORDER));
                    end
                    if (acc != '0) roots_clear = 1'b0;
                end
            end

            AST_CODEWORD_ROOTS: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |-> roots_clear); // R1
        end
    endgenerate

    rs73_pair_serializer #(.FRAME_W(FRAME_W), .PAIR_W(PAIR_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_valid (in_valid),
        .load_ready (in_ready),
        .load_frame (frame_d),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_pair   (out_pair)
    );

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> in_ready && !out_valid); // R9
endmodule

// File: tb/sim_rs73_pair_encoder.sv
module sim_rs73_pair_encoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        out_ready = 1'b0;
    logic [15:0] in_word = '0;
    logic        in_ready;
    logic        out_valid;
    logic [1:0]  out_pair;

    always #4 clk = ~clk;

    rs73_pair_encoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_pair(out_pair)
    );

    int n_checks = 0;
    int n_fail = 0;
    int exp_t [0:6];
    int log_t [0:7];

    function automatic int fmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return exp_t[(log_t[a] + log_t[b]) % 7];
    endfunction

    // Expected half from R2, R3, R4
    function automatic logic [31:0] ref_half(logic [7:0] b);
        int d [0:6];
        int g [0:4];
        int coef;
        logic [31:0] r;
        g[0] = 3; g[1] = 2; g[2] = 1; g[3] = 3; g[4] = 1;
        for (int i = 0; i < 7; i++) d[i] = 0;
        d[6] = int'(b[7:6]);
        d[5] = int'(b[5:3]);
        d[4] = int'(b[2:0]);
        for (int deg = 6; deg >= 4; deg--) begin
            coef = d[deg];
            for (int j = 0; j <= 4; j++) d[deg-4+j] = d[deg-4+j] ^ fmul(coef, g[j]);
        end
        r = '0;
        r[27:24] = {2'b00, b[7:6]};
        r[23:20] = {1'b0, b[5:3]};
        r[19:16] = {1'b0, b[2:0]};
        for (int i = 0; i < 4; i++) r[i*4 +: 4] = d[i][3:0];
        return r;
    endfunction

    // R1 and R4 on a received half
    function automatic bit half_ok(logic [31:0] h);
        int s;
        if (h[31:28] != 4'h0) return 1'b0;
        for (int i = 0; i < 7; i++) if (h[i*4+3]) return 1'b0;
        for (int j = 1; j <= 4; j++) begin
            s = 0;
            for (int i = 0; i < 7; i++) s = s ^ fmul(int'(h[i*4 +: 3]), exp_t[(i*j) % 7]);
            if (s != 0) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic run_frame(input logic [15:0] w, input bit junk);
        logic [63:0] acc;
        logic [63:0] expw;
        logic [1:0]  held_pair;
        int idx;
        int guard;
        bit held;
        bit stall_bad;
        bit busy_bad;
        expw = {ref_half(w[15:8]), ref_half(w[7:0])};
        in_word = w;
        in_valid = 1'b1;
        out_ready = 1'b0;
        guard = 0;
        while (!in_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        in_valid = junk;
        in_word = 16'($urandom);
        idx = 0; acc = '0; held = 0; stall_bad = 0; busy_bad = 0; guard = 0;
        held_pair = '0;
        while (idx < 32 && guard < 1000) begin
            if (held && (!out_valid || out_pair != held_pair)) stall_bad = 1;
            if (in_ready || !out_valid) busy_bad = 1;
            held = 0;
            if ($urandom % 4 == 0) begin
                out_ready = 1'b0;
                held = 1;
                held_pair = out_pair;
            end else begin
                out_ready = 1'b1;
                acc = {acc[61:0], out_pair};
                idx++;
                if (idx == 32) in_valid = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        out_ready = 1'b0;
        chk(acc == expw, "R3 R5 R6 frame value", acc, expw);
        chk(half_ok(acc[63:32]) && half_ok(acc[31:0]), "R1 R4 roots and padding", acc, expw);
        chk({acc[58:56], acc[54:52], acc[50:48]} == {1'b0, w[15:8]}, "R2 upper message symbols",
            64'({acc[58:56], acc[54:52], acc[50:48]}), 64'({1'b0, w[15:8]}));
        chk({acc[26:24], acc[22:20], acc[18:16]} == {1'b0, w[7:0]}, "R2 lower message symbols",
            64'({acc[26:24], acc[22:20], acc[18:16]}), 64'({1'b0, w[7:0]}));
        chk(!stall_bad, "R7 pair held under stall", 64'(stall_bad), 64'(0));
        chk(!busy_bad, "R8 in_ready low while frame pending", 64'(busy_bad), 64'(0));
        chk(!out_valid && in_ready, "R7 R8 frame ends after 32 pairs",
            64'({out_valid, in_ready}), 64'(2'b01));
    endtask

    initial begin
        logic [15:0] directed [0:7];
        void'($urandom(32'd5521));
        exp_t[0] = 1;
        log_t[0] = 0;
        log_t[1] = 0;
        for (int i = 1; i < 7; i++) begin
            int v;
            v = exp_t[i-1] << 1;
            if ((v & 8) != 0) v = v ^ 11;
            exp_t[i] = v;
            log_t[v] = i;
        end
        directed[0] = 16'h0000; directed[1] = 16'hFFFF; directed[2] = 16'h0001;
        directed[3] = 16'h8000; directed[4] = 16'h00FF; directed[5] = 16'hFF00;
        directed[6] = 16'h4040; directed[7] = 16'h0207;
        repeat (3) @(negedge clk);
        chk(!out_valid && in_ready, "R9 idle during reset", 64'({out_valid, in_ready}), 64'(2'b01));
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && in_ready, "R9 idle after reset", 64'({out_valid, in_ready}), 64'(2'b01));
        for (int i = 0; i < 8; i++) run_frame(directed[i], i[0]);
        for (int i = 0; i < 40; i++) run_frame(16'($urandom), ($urandom % 2) == 1);
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule